// File: doc/BRIEF.md
# SDRAM Memory Controller

This block sits between a simple host request port and a four-bank single-data-rate SDRAM with an 8-bit data path. After reset it holds the memory in a quiet state for a programmable settling time. It then brings the device up: one precharge that closes all banks, two auto-refresh operations and a mode-register write that sets the read latency. Once that is done it accepts one read or write at a time. Each request carries a flat 24-bit word address, which the controller splits into bank, row and column fields on the shared address pins.

Every access follows a closed-page policy: activate the row, issue one column command, then precharge the same bank. Read data is captured from the device a fixed number of clocks after the read command, set by the CAS latency parameter (2 or 3). A free-running interval timer raises a refresh request. That request is served as soon as the access in progress has closed, and it takes priority over any waiting host request. All device pins are driven from registers. The data bus is split into an output, an output-enable and an input, so the three-state buffer can sit at the chip edge.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is high, clock enable is low, data mask is high, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and req_ready and rd_valid are low.
- R2: The first non-NOP commands come at least T_POWERUP cycles after reset is released, in this order: precharge (0010) with address bit 10 high, refresh (0001), refresh, then mode set (0000). The mode set has bank 0 and an address with the CAS latency in bits 6:4 and all other bits zero. req_ready stays low until the mode set has been issued.
- R3: Clock enable is high in the cycle before any non-NOP command, and it never falls again once it has risen.
- R4: For an accepted request, address bits 23:22 give the bank and bits 21:10 give the row, driven with the activate (0011). Bits 9:0 give the column, driven with read (0101) or write (0100) on address bits 9:0 with bits 11:10 low. The activate and the column command use the same bank.
- R5: The column command comes exactly T_RCD cycles after its activate.
- R6: An activate or refresh comes at least T_RP cycles after a precharge. Any activate comes at least T_RFC cycles after a refresh and at least T_RC cycles after the previous activate.
- R7: Every activate is closed by a precharge of the same bank, with address bit 10 low, exactly T_CLOSE cycles after the column command. No activate or periodic refresh is issued while a row is open.
- R8: rd_valid pulses for one cycle, exactly CAS_LAT+1 cycles after a read command appears on the pins. rd_data holds the sd_dq_in value present at the clock edge CAS_LAT cycles after the device sampled the read.
- R9: sd_dq_oe is high only in the cycle of a write command, and in that cycle sd_dq_out carries the request's write data.
- R10: After the mode set, periodic refreshes follow each other (and follow the mode set) at intervals within 16 cycles of REF_INTERVAL. A pending refresh wins over a waiting request.
- R11: A request is taken on a clock edge where req_valid and req_ready are both high, and its activate appears on the pins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Flat word address {bank, row, column} |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Captured read data |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 8 | Write data toward the device |
| sd_dq_oe | output | 1 | Output enable for the data pins |
| sd_dq_in | input | 8 | Data returned by the device |

## Verification
If the wait counter is corrupted, the next command lands early or late. The port-side timing monitor sees this in the same cycle the command appears. A lost open-row flag or a wrong bank latch shows as an activate or refresh with a row still open, or a precharge to the wrong bank, in that access. An off-by-one in the latency pipeline moves rd_valid by a cycle and pulls in the noise the bench drives on the data input, so the very next read fails. A stuck refresh timer shows as a refresh gap outside its window, at the latest when the run ends.

// File: rtl/sdram_pkg.sv
package sdram_pkg;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 10;
    localparam int DQ_W   = 8;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int AP_BIT = 10;   // auto/all-bank select bit on the address pins

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IREF1,
        ST_IREF2,
        ST_IMRS,
        ST_IDLE,
        ST_COLUMN,
        ST_CLOSE
    } state_e;

    typedef struct packed {
        logic              write;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DQ_W-1:0]   wdata;
    } access_t;

    function automatic access_t split_req(input logic write,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [DQ_W-1:0] wdata);
        access_t a;
        a.write = write;
        a.bank  = addr[ADDR_W-1 -: BANK_W];
        a.row   = addr[COL_W +: ROW_W];
        a.col   = addr[COL_W-1:0];
        a.wdata = wdata;
        return a;
    endfunction

    // burst length 1, sequential, latency in bits 6:4
    function automatic logic [ROW_W-1:0] mode_word(input int cas_lat);
        logic [ROW_W-1:0] mw;
        mw      = '0;
        mw[6:4] = 3'(cas_lat);
        return mw;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ack,
    output logic pending
);
    localparam int CNT_W = $clog2(INTERVAL);

    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick = enable && (cnt == CNT_W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (!enable || tick) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
            pending <= (pending && !ack) || tick;
        end
    end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
    parameter int CAS_LAT = 3,
    parameter int DQ_W    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [DQ_W-1:0] dq_in,
    output logic            valid,
    output logic [DQ_W-1:0] data
);
    // pipe[k] high: a read command has been on the pins for k+1 cycles
    logic [CAS_LAT:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe  <= '0;
            valid <= 1'b0;
            data  <= '0;
        end else begin
            pipe  <= {pipe[CAS_LAT-1:0], issue};
            valid <= pipe[CAS_LAT];
            if (pipe[CAS_LAT]) data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
    import sdram_pkg::*;
#(
    parameter int CAS_LAT      = 3,
    parameter int T_POWERUP    = 25000,
    parameter int REF_INTERVAL = 1953,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int T_RFC        = 9,
    parameter int T_MRD        = 2,
    parameter int T_CLOSE      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic              sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    localparam int WAIT_MAX = max2(T_POWERUP, max2(T_RFC, max2(T_RP,
                              max2(T_RCD, max2(T_CLOSE, T_MRD)))));
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int RC_W     = $clog2(T_RC + 1);

    state_e            state;
    cmd_e              cmd_q;
    access_t           cur;
    logic [WAIT_W-1:0] wait_cnt;
    logic [RC_W-1:0]   rc_cnt;
    logic              wait_done, init_done, ref_pend, ref_ack, rd_issue;

    assign wait_done = (wait_cnt == '0);
    assign req_ready = (state == ST_IDLE) && wait_done && (rc_cnt == '0) && !ref_pend;
    assign ref_ack   = (state == ST_IDLE) && wait_done && ref_pend;
    assign rd_issue  = (state == ST_COLUMN) && wait_done && !cur.write;

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PWRUP;
            wait_cnt  <= WAIT_W'(T_POWERUP - 1);
            rc_cnt    <= '0;
            cmd_q     <= CMD_NOP;
            cur       <= '0;
            init_done <= 1'b0;
            sd_cke    <= 1'b0;
            sd_dqm    <= 1'b1;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
        end else begin
            cmd_q    <= CMD_NOP;
            sd_dq_oe <= 1'b0;
            sd_cke   <= 1'b1;
            if (rc_cnt != '0) rc_cnt <= rc_cnt - 1'b1;
            if (!wait_done) begin
                wait_cnt <= wait_cnt - 1'b1;
            end else begin
                unique case (state)
                    ST_PWRUP: begin
                        cmd_q    <= CMD_PRE;
                        sd_addr  <= ROW_W'(1) << AP_BIT;
                        state    <= ST_IREF1;
                        wait_cnt <= WAIT_W'(T_RP - 1);
                    end
                    ST_IREF1: begin
                        cmd_q    <= CMD_REF;
                        state    <= ST_IREF2;
                        wait_cnt <= WAIT_W'(T_RFC - 1);
                    end
                    ST_IREF2: begin
                        cmd_q    <= CMD_REF;
                        state    <= ST_IMRS;
                        wait_cnt <= WAIT_W'(T_RFC - 1);
                    end
                    ST_IMRS: begin
                        cmd_q     <= CMD_MRS;
                        sd_ba     <= '0;
                        sd_addr   <= mode_word(CAS_LAT);
                        state     <= ST_IDLE;
                        wait_cnt  <= WAIT_W'(T_MRD - 1);
                        init_done <= 1'b1;
                        sd_dqm    <= 1'b0;
                    end
                    ST_IDLE: begin
                        if (ref_pend) begin
                            cmd_q    <= CMD_REF;
                            wait_cnt <= WAIT_W'(T_RFC - 1);
                        end else if (req_valid && rc_cnt == '0) begin
                            cur      <= split_req(req_write, req_addr, req_wdata);
                            cmd_q    <= CMD_ACT;
                            sd_ba    <= req_addr[ADDR_W-1 -: BANK_W];
                            sd_addr  <= req_addr[COL_W +: ROW_W];
                            rc_cnt   <= RC_W'(T_RC - 1);
                            state    <= ST_COLUMN;
                            wait_cnt <= WAIT_W'(T_RCD - 1);
                        end
                    end
                    ST_COLUMN: begin
                        cmd_q     <= cur.write ? CMD_WR : CMD_RD;
                        sd_ba     <= cur.bank;
                        sd_addr   <= ROW_W'(cur.col);
                        sd_dq_oe  <= cur.write;
                        sd_dq_out <= cur.wdata;
                        state     <= ST_CLOSE;
                        wait_cnt  <= WAIT_W'(T_CLOSE - 1);
                    end
                    ST_CLOSE: begin
                        cmd_q    <= CMD_PRE;
                        sd_ba    <= cur.bank;
                        sd_addr  <= '0;
                        state    <= ST_IDLE;
                        wait_cnt <= WAIT_W'(T_RP - 1);
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk     (clk),
        .rst     (rst),
        .enable  (init_done),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    sdram_rd_capture #(.CAS_LAT(CAS_LAT), .DQ_W(DQ_W)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .issue (rd_issue),
        .dq_in (sd_dq_in),
        .valid (rd_valid),
        .data  (rd_data)
    );
endmodule

// File: rtl/sdram_ctrl_chk.sv
module sdram_ctrl_chk #(
    parameter int T_RCD = 3
) (
    input logic clk,
    input logic rst,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dq_oe,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid
);
    logic [3:0] cmd;
    logic [7:0] since_act;
    logic       mrs_seen;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 8'hFF;
            mrs_seen  <= 1'b0;
        end else begin
            if (cmd == 4'b0011)          since_act <= 8'd1;
            else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
            if (cmd == 4'b0000) mrs_seen <= 1'b1;
        end
    end

    assert_cke_stays_R3: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    assert_cmd_after_cke_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd != 4'b0111) |-> $past(cke));

    assert_oe_only_write_R9: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (cmd == 4'b0100));

    assert_accept_act_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd == 4'b0011));

    assert_col_after_rcd_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0101 || cmd == 4'b0100) |-> (32'(since_act) == T_RCD));

    assert_rdvalid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_ready_after_init_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mrs_seen || cmd == 4'b0000));
endmodule

bind sdram_ctrl sdram_ctrl_chk #(.T_RCD(T_RCD)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (sd_cke),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .dq_oe     (sd_dq_oe),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid)
);

// File: tb/sim_sdram_ctrl.sv
module sim_sdram_ctrl;
    localparam int CL      = 3;
    localparam int PWRUP   = 40;
    localparam int REFINT  = 300;
    localparam int RCD     = 3;
    localparam int RP      = 3;
    localparam int RC      = 9;
    localparam int RFC     = 9;
    localparam int MRD     = 2;
    localparam int CLOSE   = 3;

    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                           C_NOP = 4'b0111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [7:0]  sd_dq_out;
    logic [7:0]  sd_dq_in = '0;

    always #4 clk = ~clk;

    sdram_ctrl #(.CAS_LAT(CL), .T_POWERUP(PWRUP), .REF_INTERVAL(REFINT),
                 .T_RCD(RCD), .T_RP(RP), .T_RC(RC), .T_RFC(RFC), .T_MRD(MRD),
                 .T_CLOSE(CLOSE)) u0 (.*);

    int compared = 0;
    int mismatched = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    function automatic logic [7:0] seed_val(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    typedef struct {
        bit          write;
        logic [23:0] addr;
        logic [7:0]  data;
    } req_rec_t;

    req_rec_t    pend_q[$];
    req_rec_t    cur;
    int          rd_due_q[$];
    logic [7:0]  rd_exp_q[$];
    int          drv_at_q[$];
    logic [7:0]  drv_val_q[$];
    logic [7:0]  ref_mem[logic [23:0]];
    logic [7:0]  dev_mem[logic [23:0]];

    int cyc = 0, rel_cyc = -1, init_step = 0, act_due = -1;
    int last_pre = -1000, last_ref = -1000, last_act = -1000, last_col = -1000;
    int last_mrs = -1000, last_periodic = -1;
    bit open_row = 0, prev_cke = 0, saw_cke = 0;
    logic [1:0]  open_ba;
    logic [11:0] open_ra;

    // port monitor and device model, mid-cycle
    always @(negedge clk) begin
        logic [3:0]  cmd;
        logic [23:0] key;
        bit          exp_v;
        cyc++;
        cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst) begin
            if (rel_cyc < 0) rel_cyc = cyc;
            if (saw_cke) chk(sd_cke == 1'b1, "R3 cke stays high", sd_cke, 1);
            if (cmd != C_NOP) chk(prev_cke, "R3 cke before command", prev_cke, 1);
            if (sd_dq_oe) chk(cmd == C_WR, "R9 oe outside write", cmd, C_WR);

            exp_v = (rd_due_q.size() > 0) && (rd_due_q[0] == cyc);
            chk(rd_valid == exp_v, "R8 rd_valid timing", rd_valid, exp_v);
            if (exp_v) begin
                chk(rd_data == rd_exp_q[0], "R8 read data", rd_data, rd_exp_q[0]);
                void'(rd_due_q.pop_front());
                void'(rd_exp_q.pop_front());
            end

            if (req_ready) chk(init_step == 4, "R2 ready before init end", init_step, 4);
            if (req_valid && req_ready) begin
                req_rec_t r;
                r.write = req_write;
                r.addr  = req_addr;
                if (req_write) begin
                    r.data = req_wdata;
                    ref_mem[req_addr] = req_wdata;
                end else begin
                    r.data = ref_mem.exists(req_addr) ? ref_mem[req_addr] : seed_val(req_addr);
                end
                pend_q.push_back(r);
                act_due = cyc + 1;
            end

            case (cmd)
                C_PRE: begin
                    if (init_step == 0) begin
                        chk(cyc - rel_cyc >= PWRUP, "R2 power-up delay", cyc - rel_cyc, PWRUP);
                        chk(sd_addr[10] == 1'b1, "R2 precharge all", sd_addr[10], 1);
                        init_step = 1;
                    end else begin
                        chk(open_row, "R7 precharge without open row", open_row, 1);
                        chk(sd_addr[10] == 1'b0, "R7 single-bank precharge", sd_addr[10], 0);
                        chk(sd_ba == open_ba, "R7 precharge bank", sd_ba, open_ba);
                        chk(cyc - last_col == CLOSE, "R7 close delay", cyc - last_col, CLOSE);
                        open_row = 0;
                    end
                    last_pre = cyc;
                end
                C_REF: begin
                    chk(cyc - last_pre >= RP, "R6 refresh after precharge", cyc - last_pre, RP);
                    chk(cyc - last_ref >= RFC, "R6 refresh spacing", cyc - last_ref, RFC);
                    if (init_step == 1 || init_step == 2) begin
                        init_step++;
                    end else begin
                        chk(init_step == 4, "R2 refresh order", init_step, 4);
                        chk(!open_row, "R7 refresh with open row", open_row, 0);
                        chk((cyc - last_periodic >= REFINT - 16) && (cyc - last_periodic <= REFINT + 16),
                            "R10 refresh interval", cyc - last_periodic, REFINT);
                        last_periodic = cyc;
                    end
                    last_ref = cyc;
                end
                C_MRS: begin
                    chk(init_step == 3, "R2 mode set order", init_step, 3);
                    chk(sd_addr == 12'(CL << 4), "R2 mode word", sd_addr, CL << 4);
                    chk(sd_ba == 2'b00, "R2 mode bank", sd_ba, 0);
                    chk(cyc - last_ref >= RFC, "R6 mode after refresh", cyc - last_ref, RFC);
                    init_step = 4;
                    last_mrs = cyc;
                    last_periodic = cyc;
                end
                C_ACT: begin
                    chk(cyc == act_due, "R11 activate after accept", cyc, act_due);
                    chk(!open_row, "R7 activate with open row", open_row, 0);
                    chk(cyc - last_pre >= RP, "R6 tRP", cyc - last_pre, RP);
                    chk(cyc - last_ref >= RFC, "R6 tRFC", cyc - last_ref, RFC);
                    chk(cyc - last_act >= RC, "R6 tRC", cyc - last_act, RC);
                    chk(cyc - last_mrs >= MRD, "R2 mode-set gap", cyc - last_mrs, MRD);
                    if (pend_q.size() > 0) begin
                        cur = pend_q.pop_front();
                        chk(sd_ba == cur.addr[23:22], "R4 activate bank", sd_ba, cur.addr[23:22]);
                        chk(sd_addr == cur.addr[21:10], "R4 row", sd_addr, cur.addr[21:10]);
                    end else begin
                        chk(0, "R11 activate without request", 1, 0);
                    end
                    open_row = 1;
                    open_ba  = sd_ba;
                    open_ra  = sd_addr;
                    last_act = cyc;
                end
                C_RD, C_WR: begin
                    chk(cyc - last_act == RCD, "R5 activate to column", cyc - last_act, RCD);
                    chk(sd_ba == cur.addr[23:22], "R4 column bank", sd_ba, cur.addr[23:22]);
                    chk(sd_addr == {2'b00, cur.addr[9:0]}, "R4 column", sd_addr, cur.addr[9:0]);
                    chk((cmd == C_WR) == cur.write, "R4 command kind", cmd, cur.write ? C_WR : C_RD);
                    key = {sd_ba, open_ra, sd_addr[9:0]};
                    if (cmd == C_WR) begin
                        chk(sd_dq_oe == 1'b1, "R9 oe in write", sd_dq_oe, 1);
                        chk(sd_dq_out == cur.data, "R9 write data", sd_dq_out, cur.data);
                        dev_mem[key] = sd_dq_out;
                    end else begin
                        drv_at_q.push_back(cyc + CL);
                        drv_val_q.push_back(dev_mem.exists(key) ? dev_mem[key] : seed_val(key));
                        rd_due_q.push_back(cyc + 1 + CL);
                        rd_exp_q.push_back(cur.data);
                    end
                    last_col = cyc;
                end
                C_NOP: ;
                default: chk(0, "R2 illegal command", cmd, C_NOP);
            endcase
            prev_cke = sd_cke;
            if (sd_cke) saw_cke = 1;
        end
        if (drv_at_q.size() > 0 && drv_at_q[0] == cyc) begin
            sd_dq_in = drv_val_q[0];
            void'(drv_at_q.pop_front());
            void'(drv_val_q.pop_front());
        end else begin
            sd_dq_in = 8'(cyc * 37 + 11);
        end
    end

    task automatic do_req(input bit wr, input logic [23:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sd_cke == 1'b0, "R1 reset cke", sd_cke, 0);
        chk(sd_dqm == 1'b1, "R1 reset dqm", sd_dqm, 1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk(!req_ready && !rd_valid, "R1 reset outputs", {req_ready, rd_valid}, 0);
        @(posedge clk); #1;
        rst = 1'b0;

        // corner addresses
        do_req(1, 24'h000000, 8'h11);
        do_req(1, 24'hFFFFFF, 8'hEE);
        do_req(1, 24'h400000, 8'h42);
        do_req(1, 24'h2AA155, 8'hA5);
        do_req(0, 24'h000000, 8'h00);
        do_req(0, 24'hFFFFFF, 8'h00);
        do_req(0, 24'h400000, 8'h00);
        do_req(0, 24'h2AA155, 8'h00);
        do_req(0, 24'h123456, 8'h00);
        do_req(1, 24'h000000, 8'h77);
        do_req(0, 24'h000000, 8'h00);

        for (int i = 0; i < 60; i++) begin
            do_req(1, {2'(i), 12'(i * 97), 10'(i * 13 + 1)}, 8'(i * 7 + 3));
            repeat (i % 5) @(posedge clk);
        end
        for (int i = 0; i < 60; i++) begin
            do_req(0, {2'(i), 12'(i * 97), 10'(i * 13 + 1)}, 8'h00);
            repeat (i % 3) @(posedge clk);
        end

        repeat (3 * REFINT + 20) @(posedge clk);
        do_req(0, 24'hFFFFFF, 8'h00);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(rd_due_q.size() == 0, "R8 reads outstanding", rd_due_q.size(), 0);
        chk(cyc - last_periodic <= REFINT + 16, "R10 refresh still running", cyc - last_periodic, REFINT);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 100000, 0);
        summary();
        $finish;
    end
endmodule